// File: doc/BRIEF.md
# Misaligned Load/Store Access Splitter

This block sits between a processor's load/store unit and a word-organised data memory. It takes one byte, halfword or word request at any byte address. If the bytes fit inside one aligned 32-bit word, the block issues a single bus transaction. If the bytes cross into the next word, it issues two transactions, one after the other. The first goes to the lower word and the second to the following word. Every address the block places on the bus has its two low bits cleared, so the memory never has to ignore low address bits.

For a load, the block keeps the lanes returned by the first transaction. It joins them with the lanes of the second, shifts the requested bytes down to bit 0, and applies zero or sign extension. It then returns the value with a single response pulse. For a store, the block spreads the write data and the byte enables over the two words. A bus error is passed back in the same response pulse, together with the access's original, unaligned address, so a trap unit can record it. An error on the first transaction stops the second from being issued.

Top module: `mis_access_splitter`

## Requirements
- R1: After reset the block is idle: `core_ready_o` is 1, and `bus_req_o` and `core_rvalid_o` are 0.
- R2: Whenever `bus_req_o` is 1, `bus_addr_o[1:0]` is 00.
- R3: `core_size_i` encodes 0 = byte, 1 = halfword, 2 = word, and 3 is treated as word. An access whose bytes all lie in one aligned word causes exactly one bus transaction, to that word.
- R4: A halfword at offset 3, or a word at offset 1, 2 or 3, causes exactly two transactions. The first goes to the word holding the start address and the second to that word address plus 4, wrapping modulo 2^ADDR_W.
- R5: In each transaction, `bus_be_o` bit k is set exactly when byte lane k of that word belongs to the access.
- R6: For stores, access byte i (bits 8i+7:8i of `core_wdata_i`) is driven on lane (address+i) mod 4 of the transaction that covers that byte.
- R7: For loads, byte i of the access appears at bits 8i+7:8i of `core_rdata_o`. The upper bits are filled with zeros, or with copies of the top loaded bit when `core_sext_i` was 1. The value comes with exactly one `core_rvalid_o` pulse, in the cycle the last bus response arrives.
- R8: If the first transaction returns `bus_err_i`, no second transaction is issued. `core_rvalid_o` and `core_err_o` pulse together in that response cycle, with `core_err_addr_o` equal to the original request address.
- R9: If the second transaction of a split access returns an error, the response carries `core_err_o` = 1 and `core_err_addr_o` equal to the original request address. Store bytes that went to the first word stay written.
- R10: `bus_req_o` stays high with stable address, enables, write flag and write data until `bus_gnt_i` is seen. A core request is accepted only in a cycle where `core_ready_o` is 1.
- R11: Each accepted request produces exactly one `core_rvalid_o` pulse. No bus request is raised while a response is outstanding or being returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_i | input | 1 | Core access request |
| core_we_i | input | 1 | 1 = store, 0 = load |
| core_size_i | input | 2 | Access size code |
| core_sext_i | input | 1 | Sign-extend load result |
| core_addr_i | input | ADDR_W | Byte address of the access |
| core_wdata_i | input | DATA_W | Store data, byte 0 in bits 7:0 |
| core_ready_o | output | 1 | Block can accept a request |
| core_rvalid_o | output | 1 | Response pulse |
| core_rdata_o | output | DATA_W | Merged, extended load data |
| core_err_o | output | 1 | Response carries a bus error |
| core_err_addr_o | output | ADDR_W | Original address of the failing access |
| bus_req_o | output | 1 | Bus transaction request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_addr_o | output | ADDR_W | Word-aligned bus address |
| bus_we_o | output | 1 | Bus write |
| bus_be_o | output | DATA_W/8 | Bus byte enables |
| bus_wdata_o | output | DATA_W | Lane-steered write data |
| bus_rvalid_i | input | 1 | Bus response valid |
| bus_rdata_i | input | DATA_W | Bus read data |
| bus_err_i | input | 1 | Bus response error |

## Verification
The bench tries every size, offset, sign mode and direction. A design that gets the split condition wrong would either issue a second transaction for a halfword at offset 2 or drop the upper bytes of a word at offset 3, and the per-transaction comparison catches both. It also makes an access whose second word sits at address zero after the address wraps; a wrong increment there would send the upper bytes to the wrong word. Error injection on the first word and on the second word checks that a faulting first half stops the second request and that the reported address is the unaligned one, not a bus address. Read-backs after a partly failed store confirm that only the lower word changed.

// File: rtl/spl_pkg.sv
package spl_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_REQ_LO  = 3'd1,
    PH_WAIT_LO = 3'd2,
    PH_REQ_HI  = 3'd3,
    PH_WAIT_HI = 3'd4
  } phase_e;

endpackage

// File: rtl/spl_lane_map.sv
module spl_lane_map #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  be_lo_o,
  output logic [LANES-1:0]  be_hi_o,
  output logic              split_o,
  output logic [DATA_W-1:0] wdata_lo_o,
  output logic [DATA_W-1:0] wdata_hi_o
);
  import spl_pkg::*;

  logic [OFF_W:0]          nbytes;
  logic [2*LANES-1:0]      span;
  logic [2*DATA_W-1:0]     wide;
  logic [OFF_W+1:0]        first;
  logic [OFF_W+1:0]        past_end;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: nbytes = (OFF_W+1)'(1);
      SZ_HALF: nbytes = (OFF_W+1)'(2);
      default: nbytes = (OFF_W+1)'(LANES);
    endcase
  end

  assign first    = {2'b00, off_i};
  assign past_end = first + {1'b0, nbytes};

  // one flag per lane over the pair of adjacent words
  for (genvar g = 0; g < 2 * LANES; g++) begin : g_span
    assign span[g] = ((OFF_W+2)'(g) >= first) && ((OFF_W+2)'(g) < past_end);
  end

  assign be_lo_o = span[LANES-1:0];
  assign be_hi_o = span[2*LANES-1:LANES];
  assign split_o = |be_hi_o;

  assign wide       = {{DATA_W{1'b0}}, wdata_i} << {off_i, 3'b000};
  assign wdata_lo_o = wide[DATA_W-1:0];
  assign wdata_hi_o = wide[2*DATA_W-1:DATA_W];

endmodule

// File: rtl/spl_merge.sv
module spl_merge #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic              sext_i,
  output logic [DATA_W-1:0] rdata_o
);
  import spl_pkg::*;

  logic [DATA_W-1:0] raw;

  assign raw = DATA_W'({hi_i, lo_i} >> {off_i, 3'b000});

  always_comb begin
    unique case (size_i)
      SZ_BYTE: rdata_o = {{(DATA_W-8){sext_i & raw[7]}}, raw[7:0]};
      SZ_HALF: rdata_o = {{(DATA_W-16){sext_i & raw[15]}}, raw[15:0]};
      default: rdata_o = raw;
    endcase
  end

endmodule

// File: rtl/spl_seq.sv
module spl_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic split_i,
  input  logic gnt_i,
  input  logic rvalid_i,
  input  logic err_i,
  output logic ready_o,
  output logic issue_o,
  output logic hi_sel_o,
  output logic done_o,
  output logic capture_lo_o
);
  import spl_pkg::*;

  phase_e cur, nxt;

  always_comb begin
    nxt = cur;
    unique case (cur)
      PH_IDLE:    if (start_i)  nxt = PH_REQ_LO;
      PH_REQ_LO:  if (gnt_i)    nxt = PH_WAIT_LO;
      PH_WAIT_LO: if (rvalid_i) nxt = (err_i || !split_i) ? PH_IDLE : PH_REQ_HI;
      PH_REQ_HI:  if (gnt_i)    nxt = PH_WAIT_HI;
      PH_WAIT_HI: if (rvalid_i) nxt = PH_IDLE;
      default:                  nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= PH_IDLE;
    else        cur <= nxt;
  end

  assign ready_o      = (cur == PH_IDLE);
  assign issue_o      = (cur == PH_REQ_LO) || (cur == PH_REQ_HI);
  assign hi_sel_o     = (cur == PH_REQ_HI) || (cur == PH_WAIT_HI);
  assign done_o       = rvalid_i && (((cur == PH_WAIT_LO) && (err_i || !split_i)) ||
                                     (cur == PH_WAIT_HI));
  assign capture_lo_o = rvalid_i && (cur == PH_WAIT_LO) && !err_i && split_i;

endmodule

// File: rtl/mis_access_splitter.sv
module mis_access_splitter #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                core_req_i,
  input  logic                core_we_i,
  input  logic [1:0]          core_size_i,
  input  logic                core_sext_i,
  input  logic [ADDR_W-1:0]   core_addr_i,
  input  logic [DATA_W-1:0]   core_wdata_i,
  output logic                core_ready_o,
  output logic                core_rvalid_o,
  output logic [DATA_W-1:0]   core_rdata_o,
  output logic                core_err_o,
  output logic [ADDR_W-1:0]   core_err_addr_o,
  output logic                bus_req_o,
  input  logic                bus_gnt_i,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic                bus_we_o,
  output logic [DATA_W/8-1:0] bus_be_o,
  output logic [DATA_W-1:0]   bus_wdata_o,
  input  logic                bus_rvalid_i,
  input  logic [DATA_W-1:0]   bus_rdata_i,
  input  logic                bus_err_i
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [1:0]        size_q;
  logic              sext_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] lo_q;

  logic [LANES-1:0]  be_lo, be_hi;
  logic              split;
  logic [DATA_W-1:0] wd_lo, wd_hi;
  logic              hi_sel, done, cap_lo;
  logic [ADDR_W-1:0] word_lo, word_hi;
  logic [DATA_W-1:0] merge_lo, merge_hi;

  assign accept = core_req_i && core_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      size_q  <= '0;
      sext_q  <= 1'b0;
      wdata_q <= '0;
      lo_q    <= '0;
    end else begin
      if (accept) begin
        addr_q  <= core_addr_i;
        we_q    <= core_we_i;
        size_q  <= core_size_i;
        sext_q  <= core_sext_i;
        wdata_q <= core_wdata_i;
      end
      if (cap_lo) lo_q <= bus_rdata_i;
    end
  end

  spl_lane_map #(.DATA_W(DATA_W)) u_lanes (
    .off_i      (addr_q[OFF_W-1:0]),
    .size_i     (size_q),
    .wdata_i    (wdata_q),
    .be_lo_o    (be_lo),
    .be_hi_o    (be_hi),
    .split_o    (split),
    .wdata_lo_o (wd_lo),
    .wdata_hi_o (wd_hi)
  );

  spl_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (accept),
    .split_i      (split),
    .gnt_i        (bus_gnt_i),
    .rvalid_i     (bus_rvalid_i),
    .err_i        (bus_err_i),
    .ready_o      (core_ready_o),
    .issue_o      (bus_req_o),
    .hi_sel_o     (hi_sel),
    .done_o       (done),
    .capture_lo_o (cap_lo)
  );

  assign word_lo = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign word_hi = word_lo + ADDR_W'(LANES);

  assign bus_addr_o  = hi_sel ? word_hi : word_lo;
  assign bus_be_o    = hi_sel ? be_hi   : be_lo;
  assign bus_wdata_o = hi_sel ? wd_hi   : wd_lo;
  assign bus_we_o    = we_q;

  // the upper word arrives live from the bus; the lower one was held
  assign merge_lo = hi_sel ? lo_q        : bus_rdata_i;
  assign merge_hi = hi_sel ? bus_rdata_i : '0;

  spl_merge #(.DATA_W(DATA_W)) u_merge (
    .lo_i    (merge_lo),
    .hi_i    (merge_hi),
    .off_i   (addr_q[OFF_W-1:0]),
    .size_i  (size_q),
    .sext_i  (sext_q),
    .rdata_o (core_rdata_o)
  );

  assign core_rvalid_o   = done;
  assign core_err_o      = done && bus_err_i;
  assign core_err_addr_o = addr_q;

endmodule

// File: rtl/spl_checker.sv
module spl_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                core_req_i,
  input logic                core_ready_o,
  input logic                core_rvalid_o,
  input logic                core_err_o,
  input logic                bus_req_o,
  input logic                bus_gnt_i,
  input logic [ADDR_W-1:0]   bus_addr_o,
  input logic                bus_we_o,
  input logic [DATA_W/8-1:0] bus_be_o,
  input logic [DATA_W-1:0]   bus_wdata_o
);

  AST_BUS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> (bus_addr_o[1:0] == 2'b00)); // R2

  AST_BE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> (bus_be_o != '0)); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_be_o)
                                   && $stable(bus_we_o) && $stable(bus_wdata_o))); // R10

  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_i && core_ready_o) |=> bus_req_o); // R3

  AST_ERR_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    core_err_o |-> core_rvalid_o); // R8

  AST_ERR_STOPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    core_err_o |=> !bus_req_o); // R8

  AST_RESP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    core_rvalid_o |-> (!core_ready_o && !bus_req_o)); // R11

endmodule

bind mis_access_splitter spl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_req_i    (core_req_i),
  .core_ready_o  (core_ready_o),
  .core_rvalid_o (core_rvalid_o),
  .core_err_o    (core_err_o),
  .bus_req_o     (bus_req_o),
  .bus_gnt_i     (bus_gnt_i),
  .bus_addr_o    (bus_addr_o),
  .bus_we_o      (bus_we_o),
  .bus_be_o      (bus_be_o),
  .bus_wdata_o   (bus_wdata_o)
);

// File: tb/sim_mis_access_splitter.sv
module sim_mis_access_splitter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        core_req, core_we, core_sext;
  logic [1:0]  core_size;
  logic [31:0] core_addr, core_wdata;
  logic        core_ready, core_rvalid, core_err;
  logic [31:0] core_rdata, core_err_addr;
  logic        bus_req, bus_gnt, bus_we, bus_rvalid, bus_err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  bus_be;

  always #5 clk = ~clk;

  mis_access_splitter u0 (
    .clk(clk), .rst_n(rst_n),
    .core_req_i(core_req), .core_we_i(core_we), .core_size_i(core_size),
    .core_sext_i(core_sext), .core_addr_i(core_addr), .core_wdata_i(core_wdata),
    .core_ready_o(core_ready), .core_rvalid_o(core_rvalid), .core_rdata_o(core_rdata),
    .core_err_o(core_err), .core_err_addr_o(core_err_addr),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_addr_o(bus_addr), .bus_we_o(bus_we),
    .bus_be_o(bus_be), .bus_wdata_o(bus_wdata), .bus_rvalid_i(bus_rvalid),
    .bus_rdata_i(bus_rdata), .bus_err_i(bus_err)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0]  bus_mem [64];
  logic [7:0]  ref_mem [64];
  logic        err_en;
  logic [31:0] err_addr;

  logic [31:0] ex_addr [$];
  logic [3:0]  ex_be   [$];
  logic [31:0] ex_wd   [$];
  logic        ex_we   [$];
  logic        ex_err  [$];
  logic [31:0] ex_eaddr[$];
  logic [31:0] ex_data [$];
  logic        ex_load [$];

  task automatic fail(input string tag, input logic [31:0] act, input logic [31:0] exp);
    errors++;
    $display("FAIL %s: got %h expected %h", tag, act, exp);
  endtask

  // behavioural expectation for one accepted access
  task automatic model_access(input logic we, input logic [1:0] size, input logic sext,
                              input logic [31:0] addr, input logic [31:0] wdata);
    int nb;
    logic [31:0] w0, w1, a, v;
    logic [3:0]  be0, be1;
    logic [31:0] wd0, wd1;
    logic        split, e0, e1, inlo;
    nb = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    w0 = {addr[31:2], 2'b00};
    w1 = w0 + 32'd4;
    be0 = '0; be1 = '0; wd0 = '0; wd1 = '0; split = 1'b0; v = '0;
    for (int i = 0; i < nb; i++) begin
      a = addr + 32'(i);
      if (a[31:2] == w0[31:2]) begin
        be0[a[1:0]] = 1'b1;
        wd0[a[1:0]*8 +: 8] = wdata[i*8 +: 8];
      end else begin
        split = 1'b1;
        be1[a[1:0]] = 1'b1;
        wd1[a[1:0]*8 +: 8] = wdata[i*8 +: 8];
      end
    end
    e0 = err_en && (w0 == err_addr);
    e1 = err_en && split && (w1 == err_addr);
    ex_addr.push_back(w0); ex_be.push_back(be0); ex_wd.push_back(wd0); ex_we.push_back(we);
    if (split && !e0) begin
      ex_addr.push_back(w1); ex_be.push_back(be1); ex_wd.push_back(wd1); ex_we.push_back(we);
    end
    for (int i = 0; i < nb; i++) begin
      a = addr + 32'(i);
      inlo = (a[31:2] == w0[31:2]);
      if (!we) v[i*8 +: 8] = ref_mem[a[5:0]];
      else if (inlo ? !e0 : (!e0 && !e1)) ref_mem[a[5:0]] = wdata[i*8 +: 8];
    end
    if (nb == 1) v = sext ? {{24{v[7]}}, v[7:0]} : {24'd0, v[7:0]};
    if (nb == 2) v = sext ? {{16{v[15]}}, v[15:0]} : {16'd0, v[15:0]};
    ex_err.push_back(e0 || e1);
    ex_eaddr.push_back(addr);
    ex_data.push_back(v);
    ex_load.push_back(!we);
  endtask

  // bus responder with random grant and response latency
  initial begin
    bit          pend;
    int          lat;
    logic [31:0] prd;
    logic        perr;
    logic [3:0]  ebe;
    logic [31:0] emask;
    pend = 1'b0; lat = 0; prd = '0; perr = 1'b0;
    bus_gnt = 1'b0; bus_rvalid = 1'b0; bus_rdata = '0; bus_err = 1'b0;
    for (int i = 0; i < 64; i++) begin
      bus_mem[i] = 8'((i * 37 + 11) & 255);
      ref_mem[i] = 8'((i * 37 + 11) & 255);
    end
    forever begin
      @(negedge clk);
      bus_gnt = 1'b0; bus_rvalid = 1'b0; bus_err = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          bus_rvalid = 1'b1; bus_rdata = prd; bus_err = perr; pend = 1'b0;
        end else lat--;
      end else if (rst_n && bus_req && ($urandom_range(2) != 0)) begin
        checks++;
        if (ex_addr.size() == 0) fail("R3/R4 unexpected bus transaction", bus_addr, 32'hx);
        else begin
          ebe = ex_be[0];
          emask = {{8{ebe[3]}}, {8{ebe[2]}}, {8{ebe[1]}}, {8{ebe[0]}}};
          if (bus_addr != ex_addr[0]) fail("R2/R3/R4 bus address", bus_addr, ex_addr[0]);
          else if (bus_be != ebe) fail("R5 byte enables", 32'(bus_be), 32'(ebe));
          else if (bus_we != ex_we[0]) fail("R3 write flag", 32'(bus_we), 32'(ex_we[0]));
          else if (ex_we[0] && ((bus_wdata & emask) != ex_wd[0]))
            fail("R6 write lanes", bus_wdata & emask, ex_wd[0]);
          void'(ex_addr.pop_front()); void'(ex_be.pop_front());
          void'(ex_wd.pop_front());   void'(ex_we.pop_front());
        end
        perr = err_en && (bus_addr == err_addr);
        prd = perr ? 32'hDEAD_BEEF : '0;
        for (int k = 0; k < 4; k++) begin
          if (!perr && bus_we && bus_be[k]) bus_mem[{bus_addr[5:2], 2'(k)}] = bus_wdata[k*8 +: 8];
          if (!perr) prd[k*8 +: 8] = bus_mem[{bus_addr[5:2], 2'(k)}];
        end
        bus_gnt = 1'b1; pend = 1'b1; lat = $urandom_range(2);
      end
    end
  end

  // per-cycle monitor, sampled between edges
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (bus_req) begin
          checks++;
          if (bus_addr[1:0] != 2'b00) fail("R2 unaligned bus address", bus_addr, {bus_addr[31:2], 2'b00});
        end
        if (core_req && core_ready) model_access(core_we, core_size, core_sext, core_addr, core_wdata);
        if (core_rvalid) begin
          checks++;
          if (ex_err.size() == 0) fail("R11 response without request", 32'(core_rvalid), 32'd0);
          else begin
            if (core_err != ex_err[0]) fail("R8/R9 error flag", 32'(core_err), 32'(ex_err[0]));
            else if (core_err && core_err_addr != ex_eaddr[0])
              fail("R8/R9 error address", core_err_addr, ex_eaddr[0]);
            else if (!core_err && ex_load[0] && core_rdata != ex_data[0])
              fail("R7 load data", core_rdata, ex_data[0]);
            else if (ex_addr.size() != 0) fail("R8/R4 transactions left at response", 32'(ex_addr.size()), 32'd0);
            void'(ex_err.pop_front()); void'(ex_eaddr.pop_front());
            void'(ex_data.pop_front()); void'(ex_load.pop_front());
          end
        end
      end
    end
  end

  task automatic do_op(input logic we, input logic [1:0] size, input logic sext,
                       input logic [31:0] addr, input logic [31:0] wdata);
    @(negedge clk);
    while (!core_ready) @(negedge clk);
    core_req = 1'b1; core_we = we; core_size = size; core_sext = sext;
    core_addr = addr; core_wdata = wdata;
    @(negedge clk);
    core_req = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!core_ready || ex_err.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; core_req = 1'b0; core_we = 1'b0; core_size = '0; core_sext = 1'b0;
    core_addr = '0; core_wdata = '0; err_en = 1'b0; err_addr = '0;
    repeat (3) @(negedge clk);
    #2;
    checks++;
    if (!(core_ready && !bus_req && !core_rvalid))
      fail("R1 idle state in reset", {29'd0, core_ready, bus_req, core_rvalid}, 32'h4);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    checks++;
    if (!(core_ready && !bus_req && !core_rvalid))
      fail("R1 idle state after reset", {29'd0, core_ready, bus_req, core_rvalid}, 32'h4);

    // R3 R4 R5 R6 R7: every direction, size, offset and sign mode
    for (int b = 0; b < 2; b++)
      for (int we = 1; we >= 0; we--)
        for (int sz = 0; sz < 3; sz++)
          for (int off = 0; off < 4; off++)
            for (int sx = 0; sx < 2; sx++)
              do_op(1'(we), 2'(sz), 1'(sx), 32'h100 + 32'(b * 20) + 32'(off), $urandom());
    drain();

    // R4 address wrap to zero; size code 3 acts as word (R3)
    do_op(1'b1, 2'd2, 1'b0, 32'hFFFF_FFFD, 32'hA1B2_C3D4);
    do_op(1'b0, 2'd2, 1'b0, 32'hFFFF_FFFD, '0);
    do_op(1'b0, 2'd3, 1'b0, 32'h0000_0002, '0);
    do_op(1'b0, 2'd1, 1'b1, 32'hFFFF_FFFF, '0);
    drain();

    // R8 first word fails, R9 second word fails
    err_en = 1'b1; err_addr = 32'h0000_0208;
    do_op(1'b0, 2'd2, 1'b0, 32'h0000_0206, '0);
    do_op(1'b0, 2'd2, 1'b0, 32'h0000_020A, '0);
    do_op(1'b1, 2'd1, 1'b0, 32'h0000_0207, 32'h0000_5A6B);
    do_op(1'b1, 2'd2, 1'b0, 32'h0000_0209, 32'h1122_3344);
    do_op(1'b0, 2'd0, 1'b1, 32'h0000_0209, '0);
    drain();
    err_en = 1'b0;
    // R9 lower-word store bytes kept, failing word untouched
    do_op(1'b0, 2'd2, 1'b0, 32'h0000_0204, '0);
    do_op(1'b0, 2'd2, 1'b0, 32'h0000_0208, '0);
    drain();

    // mixed traffic for R7 R10 R11
    for (int n = 0; n < 300; n++)
      do_op(1'($urandom_range(1)), 2'($urandom_range(3)), 1'($urandom_range(1)),
            32'h300 + 32'($urandom_range(63)), $urandom());
    drain();

    checks++;
    if (ex_addr.size() != 0) fail("R11 transactions never issued", 32'(ex_addr.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule